// File: doc/BRIEF.md
# Word to Serial Frame Splitter

The block sits between a memory-side source and the transmit side of a UART bus controller. The source offers a 16-bit address and a 32-bit data word, qualified by a one-cycle-or-longer ready strobe. When the block is idle it latches the pair, answers with a one-cycle acknowledge, and then hands the word out one byte at a time. Each byte is accepted by the UART's chip-select strobe.

A mode input, sampled when the word is latched, chooses the frame length. With the address the frame has six bytes: the address high byte, the address low byte, then the data from its most significant byte down. Without the address the frame is only the four data bytes in the same order. A byte is offered only while three conditions hold: a frame is in progress, the write phase of the bus controller enables transmission, and the active-low transmit-ready input shows room in the FIFO. A busy flag marks the whole frame. When the last byte is taken the block goes idle again and waits for the next word.

Top module: `frame_splitter`

## Requirements
- R1: After reset, `frame_busy`, `byte_valid` and `word_ack` are all 0.
- R2: A `word_valid` seen while idle latches `word_addr` and `word_data`. One clock later `frame_busy` is 1 and `word_ack` is 1 for exactly one cycle.
- R3: With `addr_mode` = 1 at capture the frame is six bytes, in this order: addr[15:8], addr[7:0], data[31:24], data[23:16], data[15:8], data[7:0].
- R4: With `addr_mode` = 0 at capture the frame is four bytes, in this order: data[31:24], data[23:16], data[15:8], data[7:0].
- R5: `byte_valid` is 1 exactly when a frame is in progress, `wr_phase_en` is 1 and `tx_ready_n` is 0. The check is combinational in the current cycle.
- R6: The frame moves to its next byte only on a clock where `byte_valid` and `uart_take` are both 1. A `uart_take` while `byte_valid` is 0 is ignored, and `byte_out` holds its value until the byte is taken.
- R7: The clock that takes the last byte of a frame returns the block to idle (`frame_busy` = 0 one cycle later). A new word can be latched on the very next cycle.
- R8: A `word_valid` during a frame is ignored: no acknowledge is given and the bytes of the current frame stay unchanged.
- R9: A change of `addr_mode` during a frame has no effect on that frame's length or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_mode | input | 1 | 1: send the address bytes, 0: data bytes only (sampled at capture) |
| word_addr | input | 16 | Address from the memory side |
| word_data | input | 32 | Data word from the memory side |
| word_valid | input | 1 | Address and data are ready |
| word_ack | output | 1 | One-cycle pulse: word latched |
| wr_phase_en | input | 1 | Transmission enable from the bus controller's write phase |
| tx_ready_n | input | 1 | Active-low: 0 means the transmit FIFO is not full |
| uart_take | input | 1 | UART chip-select strobe accepting the offered byte |
| byte_out | output | 8 | Byte currently offered |
| byte_valid | output | 1 | `byte_out` is offered |
| frame_busy | output | 1 | A frame is in progress |

## Verification
`word_ack` and `frame_busy` come from registers, so they are due one clock after `word_valid` is seen. The bench drives each stimulus on a falling edge and reads these results on the next falling edge. `byte_valid` and `byte_out` depend on the gating inputs without a clock delay, so the bench checks them a moment after it changes those inputs, still inside the same low clock phase. A byte advance and the end of a frame are registered, and their effect is read one falling edge after the `uart_take` was driven.

// File: rtl/fs_pkg.sv
// Shared definitions for the word-to-byte frame splitter.
// Assumes a fixed 8-bit byte lane toward the UART bus.
package fs_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/fs_capture.sv
// Word capture register: holds the address/data pair for the frame
// in progress and raises a single-cycle acknowledge when it loads.
// Assumes the load input is only raised while no frame is running.
module fs_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              ack
);
    // Latch the incoming pair on a load; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

    // Acknowledge pulse, one clock after the load request.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= load;
    end

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/fs_sequencer.sv
// Byte sequencer: tracks whether a frame is running and which byte slot
// is current. The start slot depends on whether address bytes are sent.
// Assumes advance is raised only while busy.
module fs_sequencer #(
    parameter int SLOTS      = 6,
    parameter int SKIP_SLOTS = 2,
    localparam int IDX_W     = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             with_addr,
    input  logic             advance,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SLOTS - 1);
    localparam logic [IDX_W-1:0] FIRST_FULL = '0;
    localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(SKIP_SLOTS);

    logic at_last;
    assign at_last = (idx == LAST_IDX);

    // Frame state: start sets the slot, advance steps it or ends the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= with_addr ? FIRST_FULL : FIRST_DATA;
        end else if (advance) begin
            if (at_last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx  <= idx + 1'b1;
            end
        end
    end

    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !advance && !start) |=> (busy && $stable(idx)));
    assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && advance && at_last) |=> !busy);
endmodule

// File: rtl/fs_byte_select.sv
// Byte selector: views the captured address followed by the data word
// as a list of byte slots, most significant first, and picks one slot.
// Assumes ADDR_W and DATA_W are whole multiples of the byte width.
module fs_byte_select
    import fs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int SLOTS = (ADDR_W + DATA_W) / BYTE_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    input  logic [IDX_W-1:0]  idx,
    output byte_t             sel_byte
);
    logic [ADDR_W+DATA_W-1:0] frame_bits;
    byte_t                    slot [SLOTS];

    assign frame_bits = {addr_q, data_q};

    // Slot i is the i-th byte counted from the most significant end.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot[i] = frame_bits[(SLOTS-1-i)*BYTE_W +: BYTE_W];
    end

    // Pick the current slot; out-of-range indices give zero.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (idx == IDX_W'(i)) sel_byte = slot[i];
        end
    end
endmodule

// File: rtl/frame_splitter.sv
// Top of the word-to-byte frame splitter. It captures an address/data
// pair from the memory side and offers it byte by byte to a UART bus
// controller, gated by the write-phase enable and the FIFO-ready input.
// Assumes uart_take is a one-cycle strobe per accepted byte.
module frame_splitter
    import fs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_mode,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_ack,
    input  logic              wr_phase_en,
    input  logic              tx_ready_n,
    input  logic              uart_take,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_valid,
    output logic              frame_busy
);
    localparam int ADDR_SLOTS = ADDR_W / BYTE_W;
    localparam int SLOTS      = (ADDR_W + DATA_W) / BYTE_W;
    localparam int IDX_W      = $clog2(SLOTS);

    logic              start;
    logic              advance;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    byte_t             sel_byte;

    // Accept a new word only while idle; step on an accepted offer.
    assign start      = word_valid && !frame_busy;
    assign byte_valid = frame_busy && wr_phase_en && !tx_ready_n;
    assign advance    = byte_valid && uart_take;
    assign byte_out   = sel_byte;

    fs_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .addr_in (word_addr),
        .data_in (word_data),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .ack     (word_ack)
    );

    fs_sequencer #(.SLOTS(SLOTS), .SKIP_SLOTS(ADDR_SLOTS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .with_addr (addr_mode),
        .advance   (advance),
        .busy      (frame_busy),
        .idx       (idx)
    );

    fs_byte_select #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
        .addr_q   (addr_q),
        .data_q   (data_q),
        .idx      (idx),
        .sel_byte (sel_byte)
    );

    assert_ack_with_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_ack |-> frame_busy);
    assert_no_ack_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_ack |-> !$past(frame_busy));
    assert_byte_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_busy && !advance) |=> $stable(byte_out));
    assert_valid_needs_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_n |-> !byte_valid);
endmodule

// File: tb/frame_splitter_tb.sv
module frame_splitter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_mode;
    logic [15:0] word_addr;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_ack;
    logic        wr_phase_en;
    logic        tx_ready_n;
    logic        uart_take;
    logic [7:0]  byte_out;
    logic        byte_valid;
    logic        frame_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    frame_splitter u_dut (
        .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode),
        .word_addr(word_addr), .word_data(word_data), .word_valid(word_valid),
        .word_ack(word_ack), .wr_phase_en(wr_phase_en), .tx_ready_n(tx_ready_n),
        .uart_take(uart_take), .byte_out(byte_out), .byte_valid(byte_valid),
        .frame_busy(frame_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input bit mode, input logic [15:0] a,
                                            input logic [31:0] d, input int k);
        int s;
        s = mode ? k : k + 2;
        if (s < 2) return 8'((a >> (8 * (1 - s))) & 16'hFF);
        return 8'((d >> (8 * (5 - s))) & 32'hFF);
    endfunction

    // One frame: capture, optional stress on gating/ignored inputs, byte walk.
    task automatic send_frame(input bit mode, input logic [15:0] a,
                              input logic [31:0] d, input bit stress);
        int n;
        n = mode ? 6 : 4;
        @(negedge clk);
        chk("R7 idle before word", {31'b0, frame_busy}, 0);
        addr_mode = mode; word_addr = a; word_data = d; word_valid = 1'b1;
        wr_phase_en = 1'b1; tx_ready_n = 1'b0; uart_take = 1'b0;
        @(negedge clk);
        chk("R2 ack pulse", {31'b0, word_ack}, 1);
        chk("R2 busy after capture", {31'b0, frame_busy}, 1);
        word_valid = 1'b0;
        if (stress) begin
            addr_mode = ~mode;                          // R9: ignored mid-frame
            word_valid = 1'b1; word_addr = ~a; word_data = ~d;   // R8
        end
        for (int k = 0; k < n; k++) begin
            if (stress) begin
                tx_ready_n = 1'b1; uart_take = 1'b1; wr_phase_en = 1'b1;
                #1 chk("R5 fifo full blocks", {31'b0, byte_valid}, 0);
                @(negedge clk);
                chk("R8 no ack during frame", {31'b0, word_ack}, 0);
                tx_ready_n = 1'b0; wr_phase_en = 1'b0;
                #1 chk("R5 write phase off blocks", {31'b0, byte_valid}, 0);
                @(negedge clk);
                chk("R6 ignored take keeps byte", {24'b0, byte_out}, {24'b0, exp_byte(mode, a, d, k)});
                if (k == 0) word_valid = 1'b0;
            end
            wr_phase_en = 1'b1; tx_ready_n = 1'b0; uart_take = 1'b0;
            #1 chk("R5 offered", {31'b0, byte_valid}, 1);
            chk(mode ? "R3 byte order" : "R4 byte order", {24'b0, byte_out},
                {24'b0, exp_byte(mode, a, d, k)});
            @(negedge clk);
            chk("R6 holds without take", {24'b0, byte_out}, {24'b0, exp_byte(mode, a, d, k)});
            uart_take = 1'b1;
            @(negedge clk);
            uart_take = 1'b0;
            if (k == n - 1) begin
                chk("R7 idle after last byte", {31'b0, frame_busy}, 0);
                chk("R7 nothing offered", {31'b0, byte_valid}, 0);
            end else begin
                chk(mode ? "R3 still busy" : "R4 still busy", {31'b0, frame_busy}, 1);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr_mode = 1'b0; word_addr = '0; word_data = '0;
        word_valid = 1'b0; wr_phase_en = 1'b1; tx_ready_n = 1'b0; uart_take = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy at reset", {31'b0, frame_busy}, 0);
        chk("R1 valid at reset", {31'b0, byte_valid}, 0);
        chk("R1 ack at reset", {31'b0, word_ack}, 0);
        rst_n = 1'b1;

        send_frame(1'b1, 16'h0000, 32'h0000_0000, 1'b0);
        send_frame(1'b0, 16'hFFFF, 32'hFFFF_FFFF, 1'b0);
        send_frame(1'b1, 16'hA5C3, 32'h1234_5678, 1'b1);
        send_frame(1'b0, 16'h5A3C, 32'h89AB_CDEF, 1'b1);
        for (int i = 1; i <= 8; i++) begin
            for (int m = 0; m < 2; m++) begin
                send_frame(m[0], 16'(i * 16'h1357), 32'(i * 32'h9E37_79B9), i[0]);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule